// File: doc/BRIEF.md
# Quad-Channel Interrupt Pin Router

The block sits between four serial channels and the device's interrupt pins. Each channel provides an interrupt request, a per-channel output gate bit (bit 3 of its modem control register), and active-low transmit-ready and receive-ready flags. A bus-style input chooses between two pin schemes.

In Intel-style mode, each channel has its own pin. The pin carries that channel's request and has its own output enable. In Motorola-style mode, the first pin is a single shared request that is active low and open drain, and the other three pins are held low. A separate interrupt-select input can force all Intel-style pins to be driven continuously.

Every pin is given as a data bit plus an output enable, so that tri-state and open-drain drivers can be modelled outside the block. The four transmit-ready flags are also merged into one device-level flag, and the four receive-ready flags into another.

All inputs pass through one register stage. The outputs are combinational from those registers.

Top module: `quad_irq_pin_router`

## Requirements
- R1: With `bus_intel`=1, `pin_data[i]` equals channel i's registered interrupt request (active high).
- R2: With `bus_intel`=1 and `irq_force`=0, `pin_oe[i]` equals channel i's registered `chan_gate[i]` (1 = driven, 0 = high impedance).
- R3: While `rst_n` is low, and after reset until new inputs are registered, all gate bits read as 0, the mode reads as Intel-style, and `irq_force` reads as 0. So every `pin_oe` is 0 and both device-level ready flags are 1.
- R4: With `bus_intel`=1 and `irq_force`=1, every `pin_oe` is 1 whatever the gate bits are.
- R5: With `bus_intel`=0, `pin_data[0]` is 0. `pin_oe[0]` is 1 exactly when at least one channel request is 1, so the pin drives low and otherwise releases. Gate bits have no effect on it.
- R6: With `bus_intel`=0, pins 1 to 3 have `pin_oe`=1 and `pin_data`=0.
- R7: `dev_txrdy_n` is the AND of the four `chan_txrdy_n` bits.
- R8: `dev_rxrdy_n` is the AND of the four `chan_rxrdy_n` bits.
- R9: `cfg_err` is 1 exactly when `bus_intel`=0 and `irq_force`=1. In that case the pins still follow R5 and R6.
- R10: Every output reflects the inputs that were sampled at the previous rising clock edge. An input change has no effect on the outputs until that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_intel | input | 1 | 1 = Intel-style per-channel pins, 0 = Motorola-style shared request |
| irq_force | input | 1 | Forces all Intel-style pins to be driven |
| chan_irq | input | 4 | Per-channel interrupt request, active high |
| chan_gate | input | 4 | Per-channel output gate (modem control bit 3) |
| chan_txrdy_n | input | 4 | Per-channel transmit-ready, active low |
| chan_rxrdy_n | input | 4 | Per-channel receive-ready, active low |
| pin_data | output | 4 | Value each interrupt pin would drive |
| pin_oe | output | 4 | Output enable for each interrupt pin |
| dev_txrdy_n | output | 1 | Merged transmit-ready, active low |
| dev_rxrdy_n | output | 1 | Merged receive-ready, active low |
| cfg_err | output | 1 | Motorola-style mode with `irq_force` high |

## Verification
Pin routing and the ready-flag merge are separate functions that update in the same cycle. The stimulus also changes the bus mode in the same cycle as new requests and gate bits, and it covers every combination of mode, `irq_force`, gate bits and request bits. Each vector sets new transmit-ready and receive-ready patterns at the same time. The scoreboard compares every pin and both flags against the value expected under the new mode, one edge after the vector is applied. This would expose a merge that lags behind, or a pin that uses the old mode.

// File: rtl/quad_irq_pkg.sv
package quad_irq_pkg;
  localparam int NCH = 4;

  typedef struct packed {
    logic           intel;
    logic           force_on;
    logic [NCH-1:0] irq;
    logic [NCH-1:0] gate;
    logic [NCH-1:0] txrdy_n;
    logic [NCH-1:0] rxrdy_n;
  } irq_in_t;

  // Active-low flags: the merged flag is low when any channel is low.
  function automatic logic merge_low(input logic [NCH-1:0] flags);
    return &flags;
  endfunction

  function automatic logic any_set(input logic [NCH-1:0] v);
    return |v;
  endfunction
endpackage

// File: rtl/qirq_inreg.sv
module qirq_inreg
  import quad_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  irq_in_t d,
  output irq_in_t q
);
  localparam irq_in_t RST_VAL = '{intel: 1'b1, force_on: 1'b0,
                                  irq: '0, gate: '0,
                                  txrdy_n: '1, rxrdy_n: '1};

  logic cap_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q         <= RST_VAL;
      cap_valid <= 1'b0;
    end else begin
      q         <= d;
      cap_valid <= 1'b1;
    end
  end

  // R10: registered state is exactly the previous edge's inputs
  p_one_stage_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> (q == $past(d)));
endmodule

// File: rtl/qirq_lane.sv
module qirq_lane (
  input  logic intel,
  input  logic force_on,
  input  logic gate,
  input  logic irq,
  input  logic moto_oe,
  output logic data,
  output logic oe
);
  always_comb begin
    if (intel) begin
      data = irq;
      oe   = force_on | gate;
    end else begin
      data = 1'b0;
      oe   = moto_oe;
    end
  end
endmodule

// File: rtl/qirq_rdy_merge.sv
module qirq_rdy_merge
  import quad_irq_pkg::*;
(
  input  logic [NCH-1:0] txrdy_n,
  input  logic [NCH-1:0] rxrdy_n,
  output logic           dev_txrdy_n,
  output logic           dev_rxrdy_n
);
  assign dev_txrdy_n = merge_low(txrdy_n);
  assign dev_rxrdy_n = merge_low(rxrdy_n);
endmodule

// File: rtl/quad_irq_pin_router.sv
module quad_irq_pin_router
  import quad_irq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_intel,
  input  logic           irq_force,
  input  logic [NCH-1:0] chan_irq,
  input  logic [NCH-1:0] chan_gate,
  input  logic [NCH-1:0] chan_txrdy_n,
  input  logic [NCH-1:0] chan_rxrdy_n,
  output logic [NCH-1:0] pin_data,
  output logic [NCH-1:0] pin_oe,
  output logic           dev_txrdy_n,
  output logic           dev_rxrdy_n,
  output logic           cfg_err
);
  irq_in_t in_d, in_q;
  logic    shared_req;
  logic [NCH-1:0] lane_moto_oe;

  assign in_d = '{intel: bus_intel, force_on: irq_force, irq: chan_irq,
                  gate: chan_gate, txrdy_n: chan_txrdy_n, rxrdy_n: chan_rxrdy_n};

  qirq_inreg u_inreg (.clk(clk), .rst_n(rst_n), .d(in_d), .q(in_q));

  assign shared_req = any_set(in_q.irq);

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    // Pin 0 carries the shared request; the rest are held driven low.
    if (i == 0) begin : g_shared
      assign lane_moto_oe[i] = shared_req;
    end else begin : g_unused
      assign lane_moto_oe[i] = 1'b1;
    end
    qirq_lane u_lane (
      .intel(in_q.intel), .force_on(in_q.force_on), .gate(in_q.gate[i]),
      .irq(in_q.irq[i]), .moto_oe(lane_moto_oe[i]),
      .data(pin_data[i]), .oe(pin_oe[i]));

    // R1: a driven Intel-style pin shows its own channel
    p_own_chan_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_q.intel && pin_oe[i]) |-> (pin_data[i] == in_q.irq[i]));
    // R2: ungated lane is released when not forced
    p_gate_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_q.intel && !in_q.force_on && !in_q.gate[i]) |-> !pin_oe[i]);
  end

  qirq_rdy_merge u_rdy (
    .txrdy_n(in_q.txrdy_n), .rxrdy_n(in_q.rxrdy_n),
    .dev_txrdy_n(dev_txrdy_n), .dev_rxrdy_n(dev_rxrdy_n));

  assign cfg_err = ~in_q.intel & in_q.force_on;

  // R4: forcing keeps every pin driven
  p_force_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_q.intel && in_q.force_on) |-> (&pin_oe));
  // R5: shared request only ever drives low, and drives when any request
  p_shared_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_q.intel && pin_oe[0]) |-> !pin_data[0]);
  p_shared_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_q.intel && (in_q.irq != '0)) |-> pin_oe[0]);
  // R6: unused pins held low
  p_unused_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_q.intel |-> ((pin_oe[NCH-1:1] == '1) && (pin_data[NCH-1:1] == '0)));
  // R7 / R8: merged flag low implies some channel low
  p_tx_merge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_txrdy_n |-> ($countones(in_q.txrdy_n) < NCH));
  p_rx_merge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rxrdy_n |-> ($countones(in_q.rxrdy_n) < NCH));
  // R9: error flag never raised in Intel-style mode
  p_err_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_q.intel |-> !cfg_err);
endmodule

// File: tb/quad_irq_pin_router_tb.sv
module quad_irq_pin_router_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_intel = 1'b1, irq_force = 1'b0;
  logic [3:0] chan_irq = '0, chan_gate = '0, chan_txrdy_n = '1, chan_rxrdy_n = '1;
  logic [3:0] pin_data, pin_oe;
  logic       dev_txrdy_n, dev_rxrdy_n, cfg_err;

  int checks = 0, errors = 0;

  typedef struct {
    logic       m;
    logic       s;
    logic [3:0] data;
    logic [3:0] oe;
    logic       tx;
    logic       rx;
    logic       err;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  quad_irq_pin_router u_dut (
    .clk(clk), .rst_n(rst_n), .bus_intel(bus_intel), .irq_force(irq_force),
    .chan_irq(chan_irq), .chan_gate(chan_gate), .chan_txrdy_n(chan_txrdy_n),
    .chan_rxrdy_n(chan_rxrdy_n), .pin_data(pin_data), .pin_oe(pin_oe),
    .dev_txrdy_n(dev_txrdy_n), .dev_rxrdy_n(dev_rxrdy_n), .cfg_err(cfg_err));

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic m, input logic s, input logic [3:0] g,
                       input logic [3:0] q, input logic [3:0] tx, input logic [3:0] rx);
    exp_t e;
    @(negedge clk);
    bus_intel = m; irq_force = s; chan_gate = g; chan_irq = q;
    chan_txrdy_n = tx; chan_rxrdy_n = rx;
    e.m = m; e.s = s;
    for (int p = 0; p < 4; p++) begin
      if (m) begin
        e.data[p] = q[p];
        e.oe[p]   = s ? 1'b1 : g[p];
      end else begin
        e.data[p] = 1'b0;
        e.oe[p]   = (p == 0) ? (q != 4'd0) : 1'b1;
      end
    end
    e.tx  = (tx == 4'b1111);
    e.rx  = (rx == 4'b1111);
    e.err = (!m && s);
    sb.push_back(e);
  endtask

  // Monitor: compare just after the edge that registers each vector
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        if (e.m) begin
          chk("R1 pin data", pin_data, e.data);
          chk(e.s ? "R4 forced oe" : "R2 gated oe", pin_oe, e.oe);
        end else begin
          chk("R5 shared pin", {pin_data[0], pin_oe[0]}, {e.data[0], e.oe[0]});
          chk("R6 unused pins", {1'b0, pin_data[3:1]}, {1'b0, e.data[3:1]});
          chk("R6 unused oe", {1'b0, pin_oe[3:1]}, {1'b0, e.oe[3:1]});
        end
        chk("R7 tx merge", {3'b0, dev_txrdy_n}, {3'b0, e.tx});
        chk("R8 rx merge", {3'b0, dev_rxrdy_n}, {3'b0, e.rx});
        chk("R9 cfg err", {3'b0, cfg_err}, {3'b0, e.err});
      end
    end
  end

  initial begin
    chan_gate = 4'hF; chan_irq = 4'hF; chan_txrdy_n = 4'h0; chan_rxrdy_n = 4'h0;
    repeat (3) @(posedge clk);
    #2;
    chk("R3 reset oe", pin_oe, 4'b0000);
    chk("R3 reset flags", {2'b0, dev_txrdy_n, dev_rxrdy_n}, 4'b0011);
    chk("R3 reset err", {3'b0, cfg_err}, 4'b0000);
    @(negedge clk);
    chan_gate = '0; chan_irq = '0; chan_txrdy_n = '1; chan_rxrdy_n = '1;
    rst_n = 1'b1;
    #1;
    chk("R3 after release oe", pin_oe, 4'b0000);

    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 2; s++)
        for (int g = 0; g < 16; g++)
          for (int q = 0; q < 16; q++)
            drive(m[0], s[0], g[3:0], q[3:0], q[3:0] ^ {g[0], g[3:1]}, g[3:0] | q[3:0]);
    repeat (3) @(posedge clk);

    // R10: last vector was Intel-style with forcing; switch to shared mode
    @(negedge clk);
    bus_intel = 1'b0; irq_force = 1'b0; chan_irq = 4'b0000;
    #1;
    chk("R10 before edge", pin_oe, 4'b1111);
    @(posedge clk); #2;
    chk("R10 after edge", pin_oe, 4'b1110);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule